// File: doc/BRIEF.md
# PPS-Armed Synchronized Pulse Generator Bank

This block holds five periodic pulse generators that a time-to-digital phase measurement core uses as its stimulus. Software programs each generator's period and high time through a 32-bit register port, then sets the arm bit. The first rising edge of the PPS input after arming starts the restart pulser and the two low-rate pulsers in the same cycle. A programmable delay later, it starts the two repeating pulsers, one for the reference side and one for the radio side. Because every generator starts from the same captured PPS edge, their phases have a known relation to one another and to the second boundary.

All generators here run on one clock. Moving the radio-side pulses into their own clock domain is left to the crossing logic that follows this block. A master-reset register stops every generator and clears the capture, so the sequence can be armed again. The register port also returns a fixed signature, two revision words and a scratch register. This lets software confirm that the block is mapped at the expected address.

Top module: `pbank_top`

## Requirements
- R1: A read of offset 0x100 returns 0x73796E63. Offset 0x104 returns the REVISION_WORD parameter (default 0x00020001), and offset 0x108 returns COMPAT_WORD (default 0x00010000).
- R2: The scratch register at offset 0x10C stores any 32-bit value written to it and returns that value on read.
- R3: Each of the four wave words (reference repeating 0x020, radio repeating 0x024, reference low-rate 0x028, radio low-rate 0x02C) takes the period in bits [15:0] and the high time in bits [30:16]. Bit 31 is dropped and reads as 0.
- R4: The restart pulser takes a 24-bit period at 0x040 and a 23-bit high time at 0x044. Bits above these widths read as 0.
- R5: A generator that is not running drives its output low. After reset, every pulse output and pps_captured are low.
- R6: A running generator with period P > 1 and high time H drives high during the first H cycles of every P-cycle period. The first high cycle is the first cycle in which the generator runs. With P ≤ 1 it stays in phase 0, so the output is constant high when H > 0.
- R7: While control bit 0 (arm) is 1 and nothing has been captured, the first cycle in which pps_in is high after being low at the previous edge causes a capture. In the next cycle, pps_captured rises and the restart and both low-rate pulsers start. PPS edges are ignored while unarmed and after a capture, until master reset.
- R8: The two repeating pulsers start D+1 cycles after the restart pulser starts. D is the start-delay field, control bits [27:24], and its value after reset is 1.
- R9: A control write loads bits [27:24] only when bit 28 is set, and loads the output delay bits [19:16] (driven on pps_out_delay) only when bit 20 is set. A control write always loads arm from bit 0. A control read returns arm in bit 0, the output delay in [19:16] and the start delay in [27:24]. The strobe bits read as 0.
- R10: A write of bit 0 = 1 to offset 0x030 stops every generator, with all outputs low from the next cycle. The same write clears pps_captured and arm. Wave words and delay fields are kept.
- R11: A read of status at offset 0x008 returns bit 0 = repeating pulsers running and bit 1 = PPS captured.
- R12: Read data and rd_valid appear in the cycle after rd_en. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | PPS level, synchronous to clk |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | Read data valid, one cycle after bus_rd_en |
| restart_pulse | output | 1 | Restart pulser output |
| ref_pulse | output | 1 | Reference-side repeating pulse |
| radio_pulse | output | 1 | Radio-side repeating pulse |
| ref_slow_pulse | output | 1 | Reference-side low-rate pulse |
| radio_slow_pulse | output | 1 | Radio-side low-rate pulse |
| pps_captured | output | 1 | High once a PPS edge has been captured |
| pps_out_delay | output | 4 | Output PPS pipeline delay setting |

## Verification
A phase counter that is not cleared while its generator is idle shows up in the first period after a start as a shifted or shortened high time. The per-cycle reference model catches this in the very first cycle of the run. A wrong start-delay count moves the first repeating pulse relative to the restart pulse. The bench measures that gap directly for delays of 1, 2, 6 and 16 cycles. A stuck capture or arm flag shows up as an output that starts on an ignored PPS edge, or as an output that stays high after master reset. The cycle-by-cycle comparison of all five outputs and the capture flag reports either fault one cycle later.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
    localparam int ADDR_W        = 12;
    localparam int DATA_W        = 32;
    localparam int NUM_WAVE      = 4;
    localparam int NUM_LATE_WAVE = 2;   // first entries start after the delay
    localparam int WAVE_CNT_W    = 16;
    localparam int WAVE_HI_W     = 15;
    localparam int RS_CNT_W      = 24;
    localparam int RS_HI_W       = 23;
    localparam int DLY_W         = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL      = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_STAT      = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_WAVE_BASE = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_MRST      = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_RS_PER    = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_RS_HI     = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_SIG       = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_REV       = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_COMPAT    = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH   = 12'h10C;

    localparam logic [DATA_W-1:0] SIG_WORD = 32'h7379_6E63;

    localparam int CTL_ARM      = 0;
    localparam int CTL_ODLY_LSB = 16;
    localparam int CTL_ODLY_UPD = 20;
    localparam int CTL_SDLY_LSB = 24;
    localparam int CTL_SDLY_UPD = 28;

    typedef struct packed {
        logic [WAVE_HI_W-1:0]  high;
        logic [WAVE_CNT_W-1:0] period;
    } wave_cfg_t;

    typedef struct packed {
        logic [RS_HI_W-1:0]  high;
        logic [RS_CNT_W-1:0] period;
    } rs_cfg_t;

    function automatic logic [ADDR_W-1:0] wave_addr(int idx);
        return OFS_WAVE_BASE + ADDR_W'(4 * idx);
    endfunction

    function automatic logic [DATA_W-1:0] wave_to_word(wave_cfg_t c);
        return {1'b0, c};
    endfunction

    function automatic wave_cfg_t word_to_wave(logic [DATA_W-1:0] w);
        return wave_cfg_t'(w[WAVE_HI_W+WAVE_CNT_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(logic arm, logic [DLY_W-1:0] odly,
                                                    logic [DLY_W-1:0] sdly);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_ARM] = arm;
        w[CTL_ODLY_LSB +: DLY_W] = odly;
        w[CTL_SDLY_LSB +: DLY_W] = sdly;
        return w;
    endfunction
endpackage

// File: rtl/pbank_pulser.sv
module pbank_pulser #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] high_i,
    output logic             pulse_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap    = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, period_i};
    assign pulse_o = en_i && (cnt_q < high_i);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R6
    start_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_i) |-> cnt_q == '0);

    // R5
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (cnt_q == '0) || en_i);
endmodule

// File: rtl/pbank_regs.sv
module pbank_regs
    import pbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] REVISION_WORD = 32'h0002_0001,
    parameter logic [DATA_W-1:0] COMPAT_WORD   = 32'h0001_0000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en_i,
    input  logic                          rd_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic                          rd_valid_o,
    input  logic                          captured_i,
    input  logic                          running_i,
    output logic                          arm_o,
    output logic [DLY_W-1:0]              sdly_o,
    output logic [DLY_W-1:0]              odly_o,
    output wave_cfg_t [NUM_WAVE-1:0]      wave_o,
    output rs_cfg_t                       rs_o,
    output logic                          mrst_o
);
    logic                      ctrl_hit;
    logic                      arm_q;
    logic [DLY_W-1:0]          sdly_q;
    logic [DLY_W-1:0]          odly_q;
    wave_cfg_t [NUM_WAVE-1:0]  wave_q;
    logic [RS_CNT_W-1:0]       rs_per_q;
    logic [RS_HI_W-1:0]        rs_hi_q;
    logic [DATA_W-1:0]         scratch_q;
    logic [DATA_W-1:0]         rd_mux;

    assign ctrl_hit = wr_en_i && (addr_i == OFS_CTRL);
    assign mrst_o   = wr_en_i && (addr_i == OFS_MRST) && wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            sdly_q <= DLY_W'(1);
            odly_q <= '0;
        end else begin
            if (mrst_o) begin
                arm_q <= 1'b0;
            end else if (ctrl_hit) begin
                arm_q <= wdata_i[CTL_ARM];
            end
            if (ctrl_hit && wdata_i[CTL_SDLY_UPD]) begin
                sdly_q <= wdata_i[CTL_SDLY_LSB +: DLY_W];
            end
            if (ctrl_hit && wdata_i[CTL_ODLY_UPD]) begin
                odly_q <= wdata_i[CTL_ODLY_LSB +: DLY_W];
            end
        end
    end

    for (genvar g = 0; g < NUM_WAVE; g++) begin : g_wave_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                wave_q[g] <= '0;
            end else if (wr_en_i && (addr_i == wave_addr(g))) begin
                wave_q[g] <= word_to_wave(wdata_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_per_q  <= '0;
            rs_hi_q   <= '0;
            scratch_q <= '0;
        end else if (wr_en_i) begin
            if (addr_i == OFS_RS_PER)  rs_per_q  <= wdata_i[RS_CNT_W-1:0];
            if (addr_i == OFS_RS_HI)   rs_hi_q   <= wdata_i[RS_HI_W-1:0];
            if (addr_i == OFS_SCRATCH) scratch_q <= wdata_i;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr_i)
            OFS_CTRL:    rd_mux = ctrl_word(arm_q, odly_q, sdly_q);
            OFS_STAT:    rd_mux = {{(DATA_W-2){1'b0}}, captured_i, running_i};
            OFS_RS_PER:  rd_mux = {{(DATA_W-RS_CNT_W){1'b0}}, rs_per_q};
            OFS_RS_HI:   rd_mux = {{(DATA_W-RS_HI_W){1'b0}}, rs_hi_q};
            OFS_SIG:     rd_mux = SIG_WORD;
            OFS_REV:     rd_mux = REVISION_WORD;
            OFS_COMPAT:  rd_mux = COMPAT_WORD;
            OFS_SCRATCH: rd_mux = scratch_q;
            default:     rd_mux = '0;
        endcase
        for (int i = 0; i < NUM_WAVE; i++) begin
            if (addr_i == wave_addr(i)) rd_mux = wave_to_word(wave_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o    <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) rdata_o <= rd_mux;
        end
    end

    assign arm_o  = arm_q;
    assign sdly_o = sdly_q;
    assign odly_o = odly_q;
    assign wave_o = wave_q;
    assign rs_o   = '{high: rs_hi_q, period: rs_per_q};

    // R9
    sdly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && !wdata_i[CTL_SDLY_UPD]) |=> $stable(sdly_q));

    // R9
    odly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && !wdata_i[CTL_ODLY_UPD]) |=> $stable(odly_q));

    // R10
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mrst_o |=> !arm_q);

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);
endmodule

// File: rtl/pbank_seq.sv
module pbank_seq
    import pbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_i,
    input  logic             arm_i,
    input  logic             mrst_i,
    input  logic [DLY_W-1:0] sdly_i,
    output logic             captured_o,
    output logic             early_en_o,
    output logic             late_en_o
);
    logic             pps_q;
    logic             cap_q;
    logic             early_q;
    logic             late_q;
    logic [DLY_W-1:0] dcnt_q;
    logic             pps_rise;

    assign pps_rise = pps_i && !pps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pps_q   <= 1'b0;
            cap_q   <= 1'b0;
            early_q <= 1'b0;
            late_q  <= 1'b0;
            dcnt_q  <= '0;
        end else begin
            pps_q <= pps_i;
            if (mrst_i) begin
                cap_q   <= 1'b0;
                early_q <= 1'b0;
                late_q  <= 1'b0;
                dcnt_q  <= '0;
            end else if (arm_i && !cap_q && pps_rise) begin
                cap_q   <= 1'b1;
                early_q <= 1'b1;
                dcnt_q  <= '0;
            end else if (early_q && !late_q) begin
                if (dcnt_q == sdly_i) begin
                    late_q <= 1'b1;
                end else begin
                    dcnt_q <= dcnt_q + DLY_W'(1);
                end
            end
        end
    end

    assign captured_o = cap_q;
    assign early_en_o = early_q;
    assign late_en_o  = late_q;

    // R8
    late_after_early_chk: assert property (@(posedge clk) disable iff (rst)
        late_q |-> early_q);

    // R7
    cap_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_q) |-> $past(arm_i) && $past(pps_i));

    // R10
    cap_only_cleared_by_mrst_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_q) |-> $past(mrst_i));
endmodule

// File: rtl/pbank_top.sv
module pbank_top
    import pbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] REVISION_WORD = 32'h0002_0001,
    parameter logic [DATA_W-1:0] COMPAT_WORD   = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pps_in,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd_valid,
    output logic              restart_pulse,
    output logic              ref_pulse,
    output logic              radio_pulse,
    output logic              ref_slow_pulse,
    output logic              radio_slow_pulse,
    output logic              pps_captured,
    output logic [DLY_W-1:0]  pps_out_delay
);
    logic                     arm;
    logic                     mrst;
    logic [DLY_W-1:0]         sdly;
    wave_cfg_t [NUM_WAVE-1:0] wave_cfg;
    rs_cfg_t                  rs_cfg;
    logic                     early_en;
    logic                     late_en;
    logic [NUM_WAVE-1:0]      wave_pulse;

    pbank_regs #(
        .REVISION_WORD (REVISION_WORD),
        .COMPAT_WORD   (COMPAT_WORD)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (bus_wr_en),
        .rd_en_i    (bus_rd_en),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .rd_valid_o (bus_rd_valid),
        .captured_i (pps_captured),
        .running_i  (late_en),
        .arm_o      (arm),
        .sdly_o     (sdly),
        .odly_o     (pps_out_delay),
        .wave_o     (wave_cfg),
        .rs_o       (rs_cfg),
        .mrst_o     (mrst)
    );

    pbank_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .pps_i      (pps_in),
        .arm_i      (arm),
        .mrst_i     (mrst),
        .sdly_i     (sdly),
        .captured_o (pps_captured),
        .early_en_o (early_en),
        .late_en_o  (late_en)
    );

    pbank_pulser #(.CNT_W(RS_CNT_W)) u_restart (
        .clk      (clk),
        .rst      (rst),
        .en_i     (early_en),
        .period_i (rs_cfg.period),
        .high_i   ({1'b0, rs_cfg.high}),
        .pulse_o  (restart_pulse)
    );

    for (genvar g = 0; g < NUM_WAVE; g++) begin : g_wave
        localparam bit STARTS_LATE = (g < NUM_LATE_WAVE);
        logic run;
        assign run = STARTS_LATE ? late_en : early_en;
        pbank_pulser #(.CNT_W(WAVE_CNT_W)) u_pulser (
            .clk      (clk),
            .rst      (rst),
            .en_i     (run),
            .period_i (wave_cfg[g].period),
            .high_i   ({1'b0, wave_cfg[g].high}),
            .pulse_o  (wave_pulse[g])
        );
    end

    assign ref_pulse        = wave_pulse[0];
    assign radio_pulse      = wave_pulse[1];
    assign ref_slow_pulse   = wave_pulse[2];
    assign radio_slow_pulse = wave_pulse[3];

    // R10
    mrst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mrst |=> !(restart_pulse || ref_pulse || radio_pulse || ref_slow_pulse
                   || radio_slow_pulse || pps_captured));

    // R8
    late_not_with_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pps_captured) |-> !ref_pulse && !radio_pulse);
endmodule

// File: tb/pbank_top_tb.sv
`timescale 1ns/1ps
module pbank_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pps_in = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rd_valid;
    logic        restart_pulse, ref_pulse, radio_pulse, ref_slow_pulse, radio_slow_pulse;
    logic        pps_captured;
    logic [3:0]  pps_out_delay;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    pbank_top u_dut (
        .clk(clk), .rst(rst), .pps_in(pps_in),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_valid(bus_rd_valid),
        .restart_pulse(restart_pulse), .ref_pulse(ref_pulse), .radio_pulse(radio_pulse),
        .ref_slow_pulse(ref_slow_pulse), .radio_slow_pulse(radio_slow_pulse),
        .pps_captured(pps_captured), .pps_out_delay(pps_out_delay)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_arm, m_cap, m_rs_on, m_rp_on, pps_prev;
    int m_dly, m_odly, wait_left, rs_age, rp_age;
    int per [4];
    int hi [4];
    int rs_per, rs_hi;

    function automatic bit want(bit on, int age, int p, int h);
        int ph;
        if (!on) return 0;
        ph = (p <= 1) ? 0 : age % p;
        return ph < h;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_arm = 0; m_cap = 0; m_rs_on = 0; m_rp_on = 0;
            m_dly = 1; m_odly = 0; wait_left = 0; rs_age = 0; rp_age = 0;
            for (int i = 0; i < 4; i++) begin per[i] = 0; hi[i] = 0; end
            rs_per = 0; rs_hi = 0;
            pps_prev = 0;
        end else begin
            if (m_rs_on) rs_age++;
            if (m_rp_on) rp_age++;
            if (m_arm && !m_cap && pps_in && !pps_prev) begin
                m_cap = 1; m_rs_on = 1; rs_age = 0; wait_left = m_dly + 1;
            end else if (m_rs_on && !m_rp_on) begin
                wait_left--;
                if (wait_left == 0) begin m_rp_on = 1; rp_age = 0; end
            end
            if (bus_wr_en) begin
                case (bus_addr)
                    12'h000: begin
                        m_arm = bus_wdata[0];
                        if (bus_wdata[28]) m_dly = int'(bus_wdata[27:24]);
                        if (bus_wdata[20]) m_odly = int'(bus_wdata[19:16]);
                    end
                    12'h030: if (bus_wdata[0]) begin
                        m_arm = 0; m_cap = 0; m_rs_on = 0; m_rp_on = 0;
                    end
                    12'h020, 12'h024, 12'h028, 12'h02C: begin
                        per[(bus_addr - 12'h020) >> 2] = int'(bus_wdata[15:0]);
                        hi[(bus_addr - 12'h020) >> 2]  = int'(bus_wdata[30:16]);
                    end
                    12'h040: rs_per = int'(bus_wdata[23:0]);
                    12'h044: rs_hi  = int'(bus_wdata[22:0]);
                    default: ;
                endcase
            end
            pps_prev = pps_in;
        end
    end

    // per-cycle comparison: R5 R6 R7 R8 R9
    always @(negedge clk) begin
        if (!rst && cmp_on) begin
            chk(restart_pulse == want(m_rs_on, rs_age, rs_per, rs_hi), "R6 restart_pulse",
                restart_pulse, want(m_rs_on, rs_age, rs_per, rs_hi));
            chk(ref_pulse == want(m_rp_on, rp_age, per[0], hi[0]), "R8 ref_pulse",
                ref_pulse, want(m_rp_on, rp_age, per[0], hi[0]));
            chk(radio_pulse == want(m_rp_on, rp_age, per[1], hi[1]), "R8 radio_pulse",
                radio_pulse, want(m_rp_on, rp_age, per[1], hi[1]));
            chk(ref_slow_pulse == want(m_rs_on, rs_age, per[2], hi[2]), "R6 ref_slow_pulse",
                ref_slow_pulse, want(m_rs_on, rs_age, per[2], hi[2]));
            chk(radio_slow_pulse == want(m_rs_on, rs_age, per[3], hi[3]), "R6 radio_slow_pulse",
                radio_slow_pulse, want(m_rs_on, rs_age, per[3], hi[3]));
            chk(pps_captured == m_cap, "R7 pps_captured", pps_captured, m_cap);
            chk(int'(pps_out_delay) == m_odly, "R9 pps_out_delay", pps_out_delay, m_odly);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 0;
        chk(bus_rd_valid == 1'b1, "R12 rd_valid", bus_rd_valid, 1);
        d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        chk(d == exp, tag, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pps_blip();
        @(negedge clk); pps_in = 1;
        @(negedge clk); pps_in = 0;
    endtask

    // raises PPS and measures restart start to ref start (R8)
    task automatic measure_delay(input int exp);
        int first = -1;
        int got = -1;
        @(negedge clk); pps_in = 1;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            pps_in = 0;
            if (first < 0 && restart_pulse) first = c;
            if (first >= 0 && ref_pulse) begin got = c - first; break; end
        end
        chk(got == exp, "R8 start delay", got, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 0;
        // R5 reset state
        chk({restart_pulse, ref_pulse, radio_pulse, ref_slow_pulse, radio_slow_pulse,
             pps_captured} == 6'b0, "R5 outputs after reset",
            {restart_pulse, ref_pulse, radio_pulse, ref_slow_pulse, radio_slow_pulse,
             pps_captured}, 0);
        rd_chk(12'h000, 32'h0100_0000, "R9 control reset value");
        rd_chk(12'h008, 32'h0, "R11 status after reset");
        // R1
        rd_chk(12'h100, 32'h7379_6E63, "R1 signature");
        rd_chk(12'h104, 32'h0002_0001, "R1 revision");
        rd_chk(12'h108, 32'h0001_0000, "R1 compat");
        // R2
        wr(12'h10C, 32'hA5A5_5A5A);
        rd_chk(12'h10C, 32'hA5A5_5A5A, "R2 scratch pattern A");
        wr(12'h10C, 32'h0123_4567);
        rd_chk(12'h10C, 32'h0123_4567, "R2 scratch pattern B");
        // R3 / R4
        wr(12'h020, 32'hFFFF_FFFF);
        rd_chk(12'h020, 32'h7FFF_FFFF, "R3 wave word mask");
        wr(12'h040, 32'hFFFF_FFFF);
        rd_chk(12'h040, 32'h00FF_FFFF, "R4 restart period mask");
        wr(12'h044, 32'hFFFF_FFFF);
        rd_chk(12'h044, 32'h007F_FFFF, "R4 restart high mask");
        // R12
        rd_chk(12'h200, 32'h0, "R12 unmapped read");

        // program small waves
        wr(12'h020, (32'd2 << 16) | 32'd4);
        wr(12'h024, (32'd2 << 16) | 32'd5);
        wr(12'h028, (32'd5 << 16) | 32'd10);
        wr(12'h02C, (32'd3 << 16) | 32'd12);
        wr(12'h040, 32'd20);
        wr(12'h044, 32'd10);
        rd_chk(12'h024, (32'd2 << 16) | 32'd5, "R3 wave readback");
        cmp_on = 1;

        // R7 unarmed PPS ignored
        pps_blip();
        idle(5);
        chk(pps_captured == 0, "R7 unarmed pps ignored", pps_captured, 0);

        // arm with default delay 1
        wr(12'h000, 32'h0000_0001);
        measure_delay(2);
        idle(40);
        pps_blip();                // R7 second edge ignored
        idle(30);
        rd_chk(12'h008, 32'h3, "R11 status running+captured");

        // R9 strobe behaviour
        wr(12'h000, 32'h0500_0001);
        rd_chk(12'h000, 32'h0100_0001, "R9 delay kept without strobe");
        wr(12'h000, 32'h1503_0001);
        rd_chk(12'h000, 32'h0500_0001, "R9 delay loaded, output delay kept");
        wr(12'h000, 32'h0017_0001);
        rd_chk(12'h000, 32'h0507_0001, "R9 output delay loaded");
        chk(pps_out_delay == 4'd7, "R9 pps_out_delay port", pps_out_delay, 7);

        // R10 master reset
        wr(12'h030, 32'h1);
        chk({restart_pulse, ref_pulse, radio_pulse, ref_slow_pulse, radio_slow_pulse,
             pps_captured} == 6'b0, "R10 outputs low after master reset",
            {restart_pulse, ref_pulse, radio_pulse, ref_slow_pulse, radio_slow_pulse,
             pps_captured}, 0);
        rd_chk(12'h000, 32'h0507_0000, "R10 arm cleared, delays kept");
        rd_chk(12'h008, 32'h0, "R11 status after master reset");
        rd_chk(12'h028, (32'd5 << 16) | 32'd10, "R10 wave word kept");
        idle(10);

        // rearm, delay 5
        wr(12'h000, 32'h0000_0001);
        measure_delay(6);
        idle(50);
        wr(12'h030, 32'h1);

        // delay 0
        wr(12'h000, 32'h1000_0001);
        measure_delay(1);
        idle(30);
        wr(12'h030, 32'h1);

        // delay 15 plus a period-1 wave (R6 constant high)
        wr(12'h02C, (32'd1 << 16) | 32'd1);
        wr(12'h000, 32'h1F00_0001);
        measure_delay(16);
        idle(5);
        chk(radio_slow_pulse == 1, "R6 period one stays high", radio_slow_pulse, 1);
        idle(60);
        wr(12'h030, 32'h1);
        idle(5);
        cmp_on = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule